// File: doc/BRIEF.md
# Low-Power State and Wakeup Controller

This block runs the sleep state of a serial eight-channel converter. A host opens a frame by pulling its active-low start line down and clocking the serial line. A command decoder reports the first three serial bits as a decoded code. If the code is one of the two sleep codes, this block arms. On the eighth rising serial-clock edge of that frame it enters the low-power state. It then drives the shared data pin to a fixed waiting level and raises a flag that gates the rest of the converter.

While asleep, the block compares each qualifying channel input with the level that channel had at entry. A channel qualifies when it is configured as a digital input and its wakeup enable is set. The first difference flips the data pin to the opposite level, which tells the host to wake. The flipped level is latched. The state ends only when the host returns start high. The data pin then goes back to high impedance.

The start line, the serial clock and the channel pins all pass through two-flop synchronizers on the free-running system clock. The serial clock may stop while the block is asleep. A warning output records whether either reference-select bit was set at the moment of entry, because both bits should be clear before sleep.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After reset, `dio_oe_o`, `power_down_o` and `ref_warn_o` are all 0.
- R2: Only decoded codes 3'b000 and 3'b111 arm the block. A frame carrying any other code never raises `power_down_o`, however many serial edges follow.
- R3: Entry happens on the 8th rising edge of `sclk_i` counted from the fall of `start_n_i`. After the 7th edge `power_down_o` is still 0; after the 8th it is 1.
- R4: While waiting, `dio_oe_o` is 1 and `dio_o` equals bit 0 of the code: 0 for code 3'b000, 1 for code 3'b111.
- R5: A channel i with `ch_analog_i[i]`=0 and `wake_en_i[i]`=1 whose synchronized level differs from its level at entry inverts `dio_o` relative to the waiting level.
- R6: A channel that is analog (`ch_analog_i[i]`=1) or has its wakeup disabled (`wake_en_i[i]`=0) never changes `dio_o`, whatever its level does.
- R7: Once inverted, `dio_o` holds the wake level until start rises. Later channel changes, including a return to the entry level, are ignored.
- R8: Raising `start_n_i` to 1 clears `power_down_o` and `dio_oe_o` and ends the state.
- R9: `ref_warn_o` takes the OR of `ref_sel_i[1:0]` at entry and holds that value until the next entry.
- R10: Stopping `sclk_i` after entry leaves the block asleep and its outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n_i | input | 1 | Host frame line, low during a frame |
| sclk_i | input | 1 | Host serial clock |
| cmd_valid_i | input | 1 | One-cycle pulse when the decoder has a code |
| cmd_code_i | input | 3 | Decoded frame code |
| ch_level_i | input | 8 | Raw channel logic levels |
| ch_analog_i | input | 8 | Per-channel mode, 1 = analog |
| wake_en_i | input | 8 | Per-channel wakeup enable |
| ref_sel_i | input | 2 | Reference-select bits held by the control register |
| dio_o | output | 1 | Value driven on the shared data pin |
| dio_oe_o | output | 1 | Drive enable for the data pin |
| power_down_o | output | 1 | High while in the low-power state |
| ref_warn_o | output | 1 | A reference-select bit was set at entry |

## Verification
The assertions assume a few things about the inputs. `cmd_valid_i` pulses only inside a frame, after the third serial edge and before the eighth. The serial clock and the start line change slowly enough for the synchronizers to see every level. The channel masks stay constant during the low-power state. The stimulus holds each serial-clock phase and each start change for several system cycles. It issues the code pulse between the third and fourth edges and changes the masks only outside the state. The random part draws the masks, the entry levels, the mode and the channel to toggle.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [1:0] {
    PD_IDLE   = 2'd0,
    PD_WAIT   = 2'd1,
    PD_SIGNAL = 2'd2
  } pd_state_e;

  localparam logic [2:0] CODE_SLEEP_LOW  = 3'b000;
  localparam logic [2:0] CODE_SLEEP_HIGH = 3'b111;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pdw_frame_count.sv
module pdw_frame_count #(
  parameter int ENTRY_EDGE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_s,
  input  logic sclk_s,
  output logic edge_now,
  output logic at_entry
);
  localparam int CW = $clog2(ENTRY_EDGE + 1);

  logic          sclk_q;
  logic [CW-1:0] cnt;

  assign edge_now = sclk_s & ~sclk_q;
  assign at_entry = edge_now && !start_s && (cnt == CW'(ENTRY_EDGE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (start_s)
        cnt <= '0;
      else if (edge_now && cnt != CW'(ENTRY_EDGE))
        cnt <= cnt + 1'b1;
    end
  end

  // R3: the edge count only moves on a detected serial rising edge
  assert_count_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_s && !edge_now) |=> $stable(cnt));

  // R8: a high start line clears the count
  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_s |=> (cnt == '0));
endmodule

// File: rtl/pdw_wake_mon.sv
module pdw_wake_mon #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [N-1:0] ch_s,
  input  logic [N-1:0] ch_analog,
  input  logic [N-1:0] wake_en,
  output logic         hit
);
  logic [N-1:0] base_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (capture) begin
      base_q <= ch_s;
      mask_q <= ~ch_analog & wake_en;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign diff[i] = (ch_s[i] ^ base_q[i]) & mask_q[i];
  end

  assign hit = |diff;

  // R6: channels outside the captured mask never contribute to a hit
  assert_mask_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((ch_s ^ base_q) & mask_q) == '0) |-> !hit);
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pdw_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int ENTRY_EDGE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_n_i,
  input  logic            sclk_i,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_code_i,
  input  logic [N_CH-1:0] ch_level_i,
  input  logic [N_CH-1:0] ch_analog_i,
  input  logic [N_CH-1:0] wake_en_i,
  input  logic [1:0]      ref_sel_i,
  output logic            dio_o,
  output logic            dio_oe_o,
  output logic            power_down_o,
  output logic            ref_warn_o
);
  logic            start_s;
  logic            sclk_s;
  logic [N_CH-1:0] ch_s;
  logic            edge_now;
  logic            at_entry;
  logic            hit;
  logic            armed_q;
  logic            mode_q;
  logic            capture;
  pd_state_e       state_q;

  pdw_sync #(.W(1), .RST_VAL(1'b1)) u_sync_start (
    .clk(clk), .rst_n(rst_n), .d(start_n_i), .q(start_s));
  pdw_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s));
  pdw_sync #(.W(N_CH), .RST_VAL('0)) u_sync_ch (
    .clk(clk), .rst_n(rst_n), .d(ch_level_i), .q(ch_s));

  pdw_frame_count #(.ENTRY_EDGE(ENTRY_EDGE)) u_count (
    .clk(clk), .rst_n(rst_n), .start_s(start_s), .sclk_s(sclk_s),
    .edge_now(edge_now), .at_entry(at_entry));

  assign capture = (state_q == PD_IDLE) && armed_q && at_entry;

  pdw_wake_mon #(.N(N_CH)) u_wake (
    .clk(clk), .rst_n(rst_n), .capture(capture), .ch_s(ch_s),
    .ch_analog(ch_analog_i), .wake_en(wake_en_i), .hit(hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PD_IDLE;
      armed_q    <= 1'b0;
      mode_q     <= 1'b0;
      ref_warn_o <= 1'b0;
    end else if (start_s) begin
      state_q <= PD_IDLE;
      armed_q <= 1'b0;
    end else begin
      case (state_q)
        PD_IDLE: begin
          if (cmd_valid_i &&
              (cmd_code_i == CODE_SLEEP_LOW || cmd_code_i == CODE_SLEEP_HIGH)) begin
            armed_q <= 1'b1;
            mode_q  <= cmd_code_i[0];
          end
          if (capture) begin
            state_q    <= PD_WAIT;
            ref_warn_o <= |ref_sel_i;
          end
        end
        PD_WAIT:   if (hit) state_q <= PD_SIGNAL;
        PD_SIGNAL: state_q <= PD_SIGNAL;
        default:   state_q <= PD_IDLE;
      endcase
    end
  end

  always_comb begin
    power_down_o = (state_q != PD_IDLE);
    dio_oe_o     = power_down_o;
    case (state_q)
      PD_WAIT:   dio_o = mode_q;
      PD_SIGNAL: dio_o = ~mode_q;
      default:   dio_o = 1'b0;
    endcase
  end

  // R2: entry requires a prior sleep code in this frame
  assert_entry_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down_o) |-> $past(armed_q));

  // R3: entry happens only on a detected serial edge
  assert_entry_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down_o) |-> $past(edge_now));

  // R4: the waiting level right after entry follows the selected mode
  assert_wait_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down_o) |-> (dio_o == mode_q));

  // R7: an inverted pin holds until start rises
  assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (power_down_o && (dio_o != mode_q) && !start_s) |=> (dio_o == $past(dio_o)) && power_down_o);

  // R8: a high start line leaves the pin released on the next cycle
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_s |=> !dio_oe_o && !power_down_o);
endmodule

// File: tb/test_pd_wake_ctrl.sv
module test_pd_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n_i = 1'b1;
  logic       sclk_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_code_i = 3'b0;
  logic [7:0] ch_level_i = 8'h00;
  logic [7:0] ch_analog_i = 8'h00;
  logic [7:0] wake_en_i = 8'h00;
  logic [1:0] ref_sel_i = 2'b00;
  logic       dio_o, dio_oe_o, power_down_o, ref_warn_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pd_wake_ctrl i_pd_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .start_n_i(start_n_i), .sclk_i(sclk_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .ch_level_i(ch_level_i),
    .ch_analog_i(ch_analog_i), .wake_en_i(wake_en_i), .ref_sel_i(ref_sel_i),
    .dio_o(dio_o), .dio_oe_o(dio_oe_o), .power_down_o(power_down_o),
    .ref_warn_o(ref_warn_o));

  function automatic logic exp_dio(logic mode, logic [7:0] an, logic [7:0] en, int k);
    return mode ^ (~an[k] & en[k]);
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_edge();
    sclk_i = 1'b1; wait_cyc(4);
    sclk_i = 1'b0; wait_cyc(4);
  endtask

  task automatic open_frame(logic [2:0] code);
    start_n_i = 1'b0; wait_cyc(4);
    repeat (3) host_edge();
    cmd_code_i = code; cmd_valid_i = 1'b1; wait_cyc(1);
    cmd_valid_i = 1'b0;
  endtask

  task automatic close_frame();
    start_n_i = 1'b1; wait_cyc(5);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 oe", {7'b0, dio_oe_o}, 8'h0);
    check("R1 pd", {7'b0, power_down_o}, 8'h0);
    check("R1 warn", {7'b0, ref_warn_o}, 8'h0);

    // mode 0 frame, only channel 0 qualifies, channel 7 analog and enabled
    ch_analog_i = 8'h80; wake_en_i = 8'h81; ch_level_i = 8'h00; ref_sel_i = 2'b00;
    wait_cyc(4);
    open_frame(3'b000);
    repeat (4) host_edge();
    check("R3 7th edge", {7'b0, power_down_o}, 8'h0);
    host_edge();
    check("R3 8th edge", {7'b0, power_down_o}, 8'h1);
    check("R4 mode0 oe", {7'b0, dio_oe_o}, 8'h1);
    check("R4 mode0 level", {7'b0, dio_o}, 8'h0);
    check("R9 warn clear", {7'b0, ref_warn_o}, 8'h0);
    ch_level_i = 8'h02; wait_cyc(6);
    check("R6 disabled channel", {7'b0, dio_o}, 8'h0);
    ch_level_i = 8'h82; wait_cyc(6);
    check("R6 analog channel", {7'b0, dio_o}, 8'h0);
    wait_cyc(60);
    check("R10 clock stopped", {6'b0, power_down_o, dio_o}, 8'h2);
    ch_level_i = 8'h83; wait_cyc(6);
    check("R5 mode0 wake", {7'b0, dio_o}, 8'h1);
    ch_level_i = 8'h82; wait_cyc(6);
    check("R7 hold after return", {7'b0, dio_o}, 8'h1);
    ch_level_i = 8'hFF; wait_cyc(6);
    check("R7 hold more changes", {7'b0, dio_o}, 8'h1);
    close_frame();
    check("R8 pd released", {7'b0, power_down_o}, 8'h0);
    check("R8 oe released", {7'b0, dio_oe_o}, 8'h0);

    // mode 1 frame with a reference bit set
    ch_analog_i = 8'h00; wake_en_i = 8'h10; ch_level_i = 8'h10; ref_sel_i = 2'b10;
    wait_cyc(4);
    open_frame(3'b111);
    repeat (5) host_edge();
    check("R4 mode1 level", {6'b0, dio_oe_o, dio_o}, 8'h3);
    check("R9 warn set", {7'b0, ref_warn_o}, 8'h1);
    ch_level_i = 8'h00; wait_cyc(6);
    check("R5 mode1 wake", {7'b0, dio_o}, 8'h0);
    close_frame();

    // other code never enters; warning keeps last entry value
    ref_sel_i = 2'b00;
    open_frame(3'b101);
    repeat (8) host_edge();
    check("R2 other code", {7'b0, power_down_o}, 8'h0);
    check("R9 warn held", {7'b0, ref_warn_o}, 8'h1);
    close_frame();

    // constrained random frames
    begin
      void'($urandom(32'h5eed_1234));
      for (int it = 0; it < 40; it++) begin
        logic       mode;
        logic [7:0] an, en, base;
        int         k;
        mode = 1'($urandom() & 1);
        an = 8'($urandom()); en = 8'($urandom()); base = 8'($urandom());
        k = int'($urandom() % 8);
        ch_analog_i = an; wake_en_i = en; ch_level_i = base;
        ref_sel_i = 2'($urandom());
        wait_cyc(4);
        open_frame(mode ? 3'b111 : 3'b000);
        repeat (5) host_edge();
        check("R4 random wait", {6'b0, power_down_o, dio_o}, {6'b0, 1'b1, mode});
        check("R9 random warn", {7'b0, ref_warn_o}, {7'b0, |ref_sel_i});
        ch_level_i = base ^ (8'h01 << k); wait_cyc(6);
        check("R5 R6 random toggle", {7'b0, dio_o}, {7'b0, exp_dio(mode, an, en, k)});
        close_frame();
        check("R8 random release", {7'b0, power_down_o}, 8'h0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule